// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block keeps recently approved virtual-to-physical translations so that an address can be translated without walking page tables. It is direct-mapped. Each slot has one shared translation payload and three separate tags, one for each kind of access: data read, data write and instruction fetch. A type only hits where its own tag names the page being looked up, so a page that has been approved for reading is not thereby approved for writing or fetching.

The lookup side is purely combinational. It takes a virtual address and an access type and returns a hit flag and the translated physical address. The refill side writes one approved translation on a clock edge. A flush wipes every tag. The block walks no page tables and judges no permissions. It only caches translations that the surrounding logic has already accepted.

The payload stored in a slot is the difference between the physical and the virtual address, so a hit adds it to the incoming address. When a refill names a page, the other two types keep their tags at that slot only if those tags already name the same page. A tag naming any other page is dropped.

Top module: `split_tag_tlb`

## Requirements
- R1: After reset, no lookup of any type hits at any address.
- R2: The slot is the low log2(ENTRIES) bits of the virtual page number (address >> PAGE_SHIFT). Two pages that share those bits compete for one slot, and a refill of the second evicts the first for the same type.
- R3: After a refill of type T for page P, a lookup of type T anywhere in page P hits and returns lookup address + (refill physical address − refill virtual address), modulo 2^ADDR_W.
- R4: A refill of type T does not make the other two types hit for page P unless they already held page P.
- R5: If another type's tag at the slot already names page P, that type keeps hitting after the refill and uses the new payload.
- R6: If another type's tag at the slot names a different page, the refill invalidates it, and that type then misses for its old page.
- R7: Type encoding: 0 = load, 1 = store, 2 = fetch. Code 3 is handled as load, both for lookup and for refill.
- R8: Flush invalidates every tag in all three arrays on the next edge. A flush takes priority over a refill in the same cycle, and that refill leaves nothing behind.
- R9: Lookup is combinational on the current state. A refill is not visible in its own cycle and becomes visible after the next clock edge. Without a refill or a flush, the lookup result for a fixed input stays the same.
- R10: A virtual page number of all ones is the invalid tag value and never hits, even after a refill for that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties the cache |
| lk_vaddr | input | ADDR_W | Virtual address to translate |
| lk_type | input | 2 | Access type of the lookup |
| lk_hit | output | 1 | Translation found for this type |
| lk_paddr | output | ADDR_W | Translated physical address (valid when lk_hit) |
| fill_en | input | 1 | Write an approved translation this cycle |
| fill_vaddr | input | ADDR_W | Virtual address of the translation |
| fill_paddr | input | ADDR_W | Physical address it maps to |
| fill_type | input | 2 | Access type that the translation approves |
| flush | input | 1 | Invalidate all tags |

## Verification
The bench builds the block with ENTRIES = 8, PAGE_SHIFT = 12 and ADDR_W = 64. Pages 0x5 and 0xD then land on the same slot, so eviction and cross-type invalidation can be reached with small, readable addresses. The full 64-bit width is kept so that payload wrap-around and the all-ones invalid page number can be tested at the real address size.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam int NUM_TYPES = 3;

   // Code 3 behaves as a load on both ports
   function automatic logic [1:0] acc_norm(input logic [1:0] code);
      return (code == ACC_RSVD) ? 2'(ACC_LOAD) : code;
   endfunction

endpackage

// File: rtl/tlb_tag_array.sv
module tlb_tag_array #(
   parameter int ENTRIES = 256,
   parameter int VPN_W   = 52,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic             wr_own,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [VPN_W-1:0] rd_tag
);

   localparam logic [VPN_W-1:0] TAG_NONE = '1;

   logic [VPN_W-1:0] tags [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tags[i] <= TAG_NONE;
      end else if (flush) begin
         for (int i = 0; i < ENTRIES; i++) tags[i] <= TAG_NONE;
      end else if (wr_en) begin
         if (wr_own)
            tags[wr_idx] <= wr_vpn;
         else if (tags[wr_idx] != wr_vpn)
            tags[wr_idx] <= TAG_NONE;
      end
   end

   assign rd_tag = tags[rd_idx];

endmodule

// File: rtl/tlb_offset_array.sv
module tlb_offset_array #(
   parameter int ENTRIES = 256,
   parameter int ADDR_W  = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_off,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_off
);

   logic [ADDR_W-1:0] offs [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) offs[i] <= '0;
      end else if (wr_en) begin
         offs[wr_idx] <= wr_off;
      end
   end

   assign rd_off = offs[rd_idx];

endmodule

// File: rtl/split_tag_tlb.sv
module split_tag_tlb
   import tlb_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int ENTRIES    = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_vaddr,
   input  logic [1:0]        lk_type,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_paddr,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_vaddr,
   input  logic [ADDR_W-1:0] fill_paddr,
   input  logic [1:0]        fill_type,
   input  logic              flush
);

   localparam int VPN_W = ADDR_W - PAGE_SHIFT;
   localparam int IDX_W = $clog2(ENTRIES);

   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("ENTRIES must be a power of two of at least 2");
      end
      if (PAGE_SHIFT < 1 || VPN_W <= IDX_W) begin : g_bad_split
         $error("page shift leaves too few page-number bits for the index");
      end
   endgenerate

   logic [VPN_W-1:0] lk_vpn, fill_vpn;
   logic [IDX_W-1:0] lk_idx, fill_idx;
   logic [1:0]       lk_code, fill_code;
   logic             wr_go;
   logic [VPN_W-1:0] tag_rd [NUM_TYPES];
   logic [ADDR_W-1:0] off_rd;

   assign lk_vpn    = lk_vaddr[ADDR_W-1:PAGE_SHIFT];
   assign fill_vpn  = fill_vaddr[ADDR_W-1:PAGE_SHIFT];
   assign lk_idx    = lk_vpn[IDX_W-1:0];
   assign fill_idx  = fill_vpn[IDX_W-1:0];
   assign lk_code   = acc_norm(lk_type);
   assign fill_code = acc_norm(fill_type);
   assign wr_go     = fill_en && !flush;

   for (genvar t = 0; t < NUM_TYPES; t++) begin : g_tag
      tlb_tag_array #(
         .ENTRIES (ENTRIES),
         .VPN_W   (VPN_W)
      ) u_tags (
         .clk    (clk),
         .rst_n  (rst_n),
         .flush  (flush),
         .wr_en  (fill_en),
         .wr_own (fill_code == 2'(t)),
         .wr_idx (fill_idx),
         .wr_vpn (fill_vpn),
         .rd_idx (lk_idx),
         .rd_tag (tag_rd[t])
      );
   end

   tlb_offset_array #(
      .ENTRIES (ENTRIES),
      .ADDR_W  (ADDR_W)
   ) u_offs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_go),
      .wr_idx (fill_idx),
      .wr_off (fill_paddr - fill_vaddr),
      .rd_idx (lk_idx),
      .rd_off (off_rd)
   );

   logic [VPN_W-1:0] tag_sel;
   always_comb begin
      case (lk_code)
         2'(ACC_STORE): tag_sel = tag_rd[1];
         2'(ACC_FETCH): tag_sel = tag_rd[2];
         default:       tag_sel = tag_rd[0];
      endcase
   end

   assign lk_hit   = (tag_sel == lk_vpn) && !(&lk_vpn);
   assign lk_paddr = lk_vaddr + off_rd;

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
   import tlb_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int PAGE_SHIFT = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] lk_vaddr,
   input logic [1:0]        lk_type,
   input logic              lk_hit,
   input logic [ADDR_W-1:0] lk_paddr,
   input logic              fill_en,
   input logic [ADDR_W-1:0] fill_vaddr,
   input logic [ADDR_W-1:0] fill_paddr,
   input logic [1:0]        fill_type,
   input logic              flush
);

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit); // R8

   AST_BAD_PAGE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (&lk_vaddr[ADDR_W-1:PAGE_SHIFT]) |-> !lk_hit); // R10

   AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush && !(&fill_vaddr[ADDR_W-1:PAGE_SHIFT])) |=>
      (!(lk_vaddr[ADDR_W-1:PAGE_SHIFT] == $past(fill_vaddr[ADDR_W-1:PAGE_SHIFT])
         && acc_norm(lk_type) == acc_norm($past(fill_type)))
       || (lk_hit && (lk_paddr - lk_vaddr) == $past(fill_paddr - fill_vaddr)))); // R3

   AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(fill_en) && !$past(flush) && $stable(lk_vaddr) && $stable(lk_type))
      |-> ($stable(lk_hit) && $stable(lk_paddr))); // R9

endmodule

bind split_tag_tlb tlb_checker #(
   .ADDR_W     (ADDR_W),
   .PAGE_SHIFT (PAGE_SHIFT)
) u_tlb_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_vaddr   (lk_vaddr),
   .lk_type    (lk_type),
   .lk_hit     (lk_hit),
   .lk_paddr   (lk_paddr),
   .fill_en    (fill_en),
   .fill_vaddr (fill_vaddr),
   .fill_paddr (fill_paddr),
   .fill_type  (fill_type),
   .flush      (flush)
);

// File: tb/split_tag_tlb_test.sv
`timescale 1ns/1ps
module split_tag_tlb_test;

   localparam int ADDR_W = 64;
   localparam logic [1:0] T_LD = 2'd0, T_ST = 2'd1, T_FE = 2'd2, T_RS = 2'd3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] lk_vaddr = '0;
   logic [1:0]        lk_type = '0;
   logic              lk_hit;
   logic [ADDR_W-1:0] lk_paddr;
   logic              fill_en = 1'b0;
   logic [ADDR_W-1:0] fill_vaddr = '0;
   logic [ADDR_W-1:0] fill_paddr = '0;
   logic [1:0]        fill_type = '0;
   logic              flush = 1'b0;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   split_tag_tlb #(.ADDR_W(ADDR_W), .PAGE_SHIFT(12), .ENTRIES(8)) uut (
      .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_type(lk_type),
      .lk_hit(lk_hit), .lk_paddr(lk_paddr), .fill_en(fill_en),
      .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
      .fill_type(fill_type), .flush(flush)
   );

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive a lookup and compare the combinational result
   task automatic probe(input logic [63:0] va, input logic [1:0] ty,
                        input bit exp_hit, input logic [63:0] exp_pa,
                        input string req);
      lk_vaddr = va;
      lk_type  = ty;
      #1;
      check(lk_hit == exp_hit, req, 64'(lk_hit), 64'(exp_hit));
      if (exp_hit) check(lk_paddr == exp_pa, req, lk_paddr, exp_pa);
   endtask

   task automatic fill(input logic [63:0] va, input logic [63:0] pa,
                       input logic [1:0] ty, input bit with_flush);
      @(negedge clk);
      fill_en = 1'b1; fill_vaddr = va; fill_paddr = pa; fill_type = ty;
      flush = with_flush;
      @(negedge clk);
      fill_en = 1'b0; flush = 1'b0;
   endtask

   task automatic t_reset;
      for (int t = 0; t < 4; t++) probe(64'h0, 2'(t), 1'b0, '0, "R1");
      probe(64'h5123, T_FE, 1'b0, '0, "R1");
   endtask

   task automatic t_basic;
      fill(64'h5000, 64'h8_0000_3000, T_LD, 1'b0);
      probe(64'h5abc, T_LD, 1'b1, 64'h8_0000_3abc, "R3");
      probe(64'h5abc, T_RS, 1'b1, 64'h8_0000_3abc, "R7");
      probe(64'h5abc, T_ST, 1'b0, '0, "R4");
      probe(64'h5abc, T_FE, 1'b0, '0, "R4");
   endtask

   task automatic t_timing;
      @(negedge clk);
      fill_en = 1'b1; fill_vaddr = 64'h7000; fill_paddr = 64'h1_7000; fill_type = T_ST;
      probe(64'h7004, T_ST, 1'b0, '0, "R9 same cycle");
      @(negedge clk);
      fill_en = 1'b0;
      probe(64'h7004, T_ST, 1'b1, 64'h1_7004, "R9 next edge");
   endtask

   task automatic t_keep;
      fill(64'h5000, 64'h9000, T_FE, 1'b0);
      probe(64'h5010, T_LD, 1'b1, 64'h9010, "R5");
      probe(64'h5010, T_FE, 1'b1, 64'h9010, "R5");
      probe(64'h5010, T_ST, 1'b0, '0, "R4");
   endtask

   task automatic t_evict;
      fill(64'hD000, 64'h1000, T_ST, 1'b0);
      probe(64'hD020, T_ST, 1'b1, 64'h1020, "R2");
      probe(64'h5020, T_LD, 1'b0, '0, "R6");
      probe(64'h5020, T_FE, 1'b0, '0, "R6");
      probe(64'hD020, T_LD, 1'b0, '0, "R4");
      fill(64'hD000, 64'h2000, T_ST, 1'b0);
      fill(64'h5000, 64'h6000, T_ST, 1'b0);
      probe(64'hD000, T_ST, 1'b0, '0, "R2");
      probe(64'h5008, T_ST, 1'b1, 64'h6008, "R2");
   endtask

   task automatic t_rsvd_fill;
      fill(64'h2000, 64'h4000, T_RS, 1'b0);
      probe(64'h2fff, T_LD, 1'b1, 64'h4fff, "R7");
      probe(64'h2fff, T_ST, 1'b0, '0, "R7");
   endtask

   task automatic t_wrap;
      fill(64'hFFFF_0000_0000_1000, 64'h2000, T_FE, 1'b0);
      probe(64'hFFFF_0000_0000_1FF0, T_FE, 1'b1, 64'h2FF0, "R3 wrap");
   endtask

   task automatic t_bad_page;
      fill(64'hFFFF_FFFF_FFFF_F000, 64'h0, T_LD, 1'b0);
      probe(64'hFFFF_FFFF_FFFF_F123, T_LD, 1'b0, '0, "R10");
   endtask

   task automatic t_flush;
      fill(64'h3000, 64'h5000, T_LD, 1'b1);
      probe(64'h3000, T_LD, 1'b0, '0, "R8 priority");
      probe(64'h7004, T_ST, 1'b0, '0, "R8");
      probe(64'h2000, T_LD, 1'b0, '0, "R8");
      probe(64'hFFFF_0000_0000_1000, T_FE, 1'b0, '0, "R8");
   endtask

   initial begin
      #1_000_000;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h1, 64'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_timing;
      t_keep;
      t_evict;
      t_rsvd_fill;
      t_wrap;
      t_bad_page;
      t_flush;
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule